// File: doc/BRIEF.md
# Command-Unlocked Set-to-Clear Control Register

This block holds the 32-bit main control word of a timer controller and drives it out to the timers. Software reaches it over a simple memory-mapped bus with an address, write data, a write strobe, a read strobe and registered read data. The control word can be loaded whole through a direct address. It can also be edited through a clear alias, where every 1 written clears the matching control bit.

The clear alias is guarded. It only acts after an unlock command code has been written to a separate command register. A lock command code turns it off again. Reads of the command register show whether the alias is armed. Accesses to offsets that are not mapped raise a one-cycle error pulse and change nothing.

Top module: `ctl_clr_regs`

## Requirements
- R1: After reset, `ctrl_out` is 0, the alias is locked (a read of 0x38 returns 0), `bus_rdata` is 0 and `bus_err` is 0.
- R2: A write to offset 0x30 loads all 32 bits of `bus_wdata` into the control word, whether the alias is locked or unlocked.
- R3: A write to 0x38 whose data bits [8:1] equal 0xAE unlocks the alias. After that, a read of 0x38 returns 1 in bit 0.
- R4: A write to 0x38 whose data bits [8:1] equal 0xEA locks the alias.
- R5: A write to 0x38 with any other value in bits [8:1] leaves the lock state unchanged.
- R6: While the alias is unlocked, a write to 0x3C sets the control word to its old value AND NOT the write data.
- R7: While the alias is locked, a write to 0x3C leaves the control word unchanged.
- R8: A read of 0x30 returns the control word. A read of 0x38 returns the lock state in bit 0 with every other bit 0. A read of 0x3C returns 0.
- R9: A read or write to any other offset sets `bus_err` to 1 for the next cycle, returns read data 0, and changes neither the control word nor the lock state.
- R10: All updates take effect at the clock edge that samples the strobe. The new value appears on `ctrl_out`, and read data appears on `bus_rdata`, in the following cycle.
- R11: When a read and a write to the same offset are strobed in one cycle, the read returns the value the register held before that write.
- R12: `bus_rdata` is 0 in any cycle that does not follow a read strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 8 | Byte offset of the access |
| bus_wdata | input | 32 | Write data |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 32 | Registered read data |
| bus_err | output | 1 | One-cycle pulse after an access to an unmapped offset |
| ctrl_out | output | 32 | Current control word, sent to the timers |

## Verification
Two functions can fall in the same cycle: a read and a write strobed together. A typical case is a read of 0x30 during a clear-alias write, or a read of 0x38 during a lock or unlock command. Random stimulus drives both strobes together on many cycles. A bench model then judges the read data against the register value from before the write, and judges `ctrl_out` or the later lock state against the value after the write.

// File: rtl/ctl_clr_pkg.sv
package ctl_clr_pkg;
    localparam int DATA_W  = 32;
    localparam int ADDR_W  = 8;
    localparam int CMD_LSB = 1;
    localparam int CMD_W   = 8;

    localparam logic [CMD_W-1:0] CMD_UNLOCK = 8'hAE;
    localparam logic [CMD_W-1:0] CMD_LOCK   = 8'hEA;

    localparam logic [ADDR_W-1:0] OFS_DIRECT = 8'h30;
    localparam logic [ADDR_W-1:0] OFS_CMD    = 8'h38;
    localparam logic [ADDR_W-1:0] OFS_ALIAS  = 8'h3C;

    typedef struct packed {
        logic direct;
        logic cmd;
        logic alias_w;
        logic mapped;
    } sel_t;
endpackage

// File: rtl/ctl_clr_decode.sv
module ctl_clr_decode
    import ctl_clr_pkg::*;
#(
    parameter int AW = ADDR_W
) (
    input  logic [AW-1:0] addr,
    output sel_t          sel
);
    always_comb begin
        sel         = '0;
        sel.direct  = (addr == AW'(OFS_DIRECT));
        sel.cmd     = (addr == AW'(OFS_CMD));
        sel.alias_w = (addr == AW'(OFS_ALIAS));
        sel.mapped  = sel.direct | sel.cmd | sel.alias_w;
    end
endmodule

// File: rtl/ctl_clr_unlock.sv
module ctl_clr_unlock
    import ctl_clr_pkg::*;
#(
    parameter int DW = DATA_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_cmd,
    input  logic [DW-1:0] wdata,
    output logic          alias_en
);
    localparam int CMD_MSB = CMD_LSB + CMD_W - 1;

    typedef struct packed {
        logic en;
    } st_t;

    st_t st_d, st_q;
    logic [CMD_W-1:0] cmd_code;

    always_comb begin
        cmd_code = wdata[CMD_MSB:CMD_LSB];
        st_d     = st_q;
        if (wr_cmd) begin
            if (cmd_code == CMD_UNLOCK)    st_d.en = 1'b1;
            else if (cmd_code == CMD_LOCK) st_d.en = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign alias_en = st_q.en;

    a_r3_unlock: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_cmd && wdata[CMD_MSB:CMD_LSB] == CMD_UNLOCK) |=> alias_en);
    a_r4_lock: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_cmd && wdata[CMD_MSB:CMD_LSB] == CMD_LOCK) |=> !alias_en);
    a_r5_other_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_cmd && (wdata[CMD_MSB:CMD_LSB] == CMD_LOCK ||
                     wdata[CMD_MSB:CMD_LSB] == CMD_UNLOCK)) |=> $stable(alias_en));
endmodule

// File: rtl/ctl_clr_main.sv
module ctl_clr_main
    import ctl_clr_pkg::*;
#(
    parameter int DW = DATA_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_direct,
    input  logic          wr_alias,
    input  logic          alias_en,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] ctrl
);
    typedef struct packed {
        logic [DW-1:0] word;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_direct)                st_d.word = wdata;
        else if (wr_alias && alias_en) st_d.word = st_q.word & ~wdata;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign ctrl = st_q.word;

    a_r2_direct_load: assert property (@(posedge clk) disable iff (!rst_n)
        wr_direct |=> ctrl == $past(wdata));
    a_r6_clear_only: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_alias && alias_en) |=> ((ctrl & ~$past(ctrl)) == '0));
    a_r7_locked_ignore: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_direct && !(wr_alias && alias_en)) |=> $stable(ctrl));
endmodule

// File: rtl/ctl_clr_regs.sv
module ctl_clr_regs
    import ctl_clr_pkg::*;
#(
    parameter int DW = DATA_W,
    parameter int AW = ADDR_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] bus_addr,
    input  logic [DW-1:0] bus_wdata,
    input  logic          bus_wr,
    input  logic          bus_rd,
    output logic [DW-1:0] bus_rdata,
    output logic          bus_err,
    output logic [DW-1:0] ctrl_out
);
    typedef struct packed {
        logic [DW-1:0] rdata;
        logic          err;
    } bus_st_t;

    sel_t    sel;
    logic    alias_en;
    bus_st_t bs_d, bs_q;

    ctl_clr_decode #(.AW(AW)) u_dec (
        .addr (bus_addr),
        .sel  (sel)
    );

    ctl_clr_unlock #(.DW(DW)) u_unlock (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_cmd   (bus_wr && sel.cmd),
        .wdata    (bus_wdata),
        .alias_en (alias_en)
    );

    ctl_clr_main #(.DW(DW)) u_main (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_direct (bus_wr && sel.direct),
        .wr_alias  (bus_wr && sel.alias_w),
        .alias_en  (alias_en),
        .wdata     (bus_wdata),
        .ctrl      (ctrl_out)
    );

    always_comb begin
        bs_d       = '0;
        bs_d.err   = (bus_wr || bus_rd) && !sel.mapped;
        if (bus_rd) begin
            if (sel.direct)   bs_d.rdata = ctrl_out;
            else if (sel.cmd) bs_d.rdata = DW'(alias_en);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) bs_q <= '0;
        else        bs_q <= bs_d;
    end

    assign bus_rdata = bs_q.rdata;
    assign bus_err   = bs_q.err;

    a_r9_err_cause: assert property (@(posedge clk) disable iff (!rst_n)
        bus_err |-> $past(bus_wr || bus_rd));
    a_r9_err_zero_data: assert property (@(posedge clk) disable iff (!rst_n)
        bus_err |-> bus_rdata == '0);
    a_r12_idle_rdata: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |=> bus_rdata == '0);
endmodule

// File: tb/ctl_clr_regs_test.sv
module ctl_clr_regs_test;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [7:0]  bus_addr;
    logic [31:0] bus_wdata;
    logic        bus_wr, bus_rd;
    logic [31:0] bus_rdata;
    logic        bus_err;
    logic [31:0] ctrl_out;

    int n_cmp = 0, n_bad = 0;
    bit done = 0;
    logic [31:0] m_ctrl;
    logic        m_en;

    always #2.5 clk = ~clk;

    ctl_clr_regs uut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
        .bus_err(bus_err), .ctrl_out(ctrl_out)
    );

    function automatic bit is_mapped(logic [7:0] a);
        return a == 8'h30 || a == 8'h38 || a == 8'h3C;
    endfunction

    function automatic logic [31:0] exp_read(logic [7:0] a);
        if (a == 8'h30) return m_ctrl;
        if (a == 8'h38) return {31'd0, m_en};
        return 32'd0;
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // called at a falling edge; drives one access and checks in the next cycle
    task automatic access(bit wr, bit rd, logic [7:0] a, logic [31:0] d);
        logic [31:0] e_rd;
        bit          e_err;
        string       tag;
        e_rd  = rd ? exp_read(a) : 32'd0;
        e_err = (wr || rd) && !is_mapped(a);
        tag   = (a == 8'h30) ? "R2/R10" : (a == 8'h38) ? "R3/R4/R5" :
                (a == 8'h3C) ? (m_en ? "R6" : "R7") : "R9";
        bus_addr = a; bus_wdata = d; bus_wr = wr; bus_rd = rd;
        if (wr) begin
            if (a == 8'h30) m_ctrl = d;
            else if (a == 8'h3C && m_en) m_ctrl = m_ctrl & ~d;
            else if (a == 8'h38) begin
                if (d[8:1] == 8'hAE) m_en = 1'b1;
                else if (d[8:1] == 8'hEA) m_en = 1'b0;
            end
        end
        @(negedge clk);
        check({tag, " ctrl_out"}, ctrl_out, m_ctrl);
        check((wr && rd) ? "R11 rdata" : (rd ? "R8 rdata" : "R12 rdata"), bus_rdata, e_rd);
        check("R9 err", {31'd0, bus_err}, {31'd0, e_err});
        bus_wr = 1'b0; bus_rd = 1'b0;
    endtask

    function automatic logic [31:0] cmd_word(logic [7:0] c, logic [31:0] noise);
        return (noise & ~32'h1FE) | {23'd0, c, 1'b0};
    endfunction

    initial begin
        #200000;
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        int unsigned seed;
        seed = 32'd1234;
        void'($urandom(seed));
        rst_n = 1'b0; bus_addr = '0; bus_wdata = '0; bus_wr = 0; bus_rd = 0;
        m_ctrl = '0; m_en = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1 ctrl_out", ctrl_out, 32'd0);
        check("R1 rdata", bus_rdata, 32'd0);
        check("R1 err", {31'd0, bus_err}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        access(0, 1, 8'h38, 0);                          // R1 flag locked
        access(1, 0, 8'h30, 32'hFFFF_FFFF);              // R2 while locked
        access(1, 0, 8'h3C, 32'h0000_00FF);              // R7 locked clear ignored
        access(1, 0, 8'h38, cmd_word(8'h55, 32'hFFFF_FFFF)); // R5 other code
        access(0, 1, 8'h38, 0);
        access(1, 1, 8'h38, cmd_word(8'hAE, 32'hFFFF_FFFF)); // R3 + R11 old flag
        access(0, 1, 8'h38, 0);                          // R3/R8 reads 1
        access(1, 0, 8'h38, cmd_word(8'h57, 0));         // R5 stays unlocked
        access(1, 1, 8'h3C, 32'h0F0F_0000);              // R6, R8 alias reads 0
        access(1, 1, 8'h30, 32'h1234_5678);              // R11 direct
        access(1, 0, 8'h3C, 32'd0);                      // R6 zero clears nothing
        access(1, 0, 8'h44, 32'hFFFF_FFFF);              // R9 unmapped write
        access(0, 1, 8'h00, 0);                          // R9 unmapped read
        access(0, 1, 8'h30, 0);                          // R9 no state change
        access(1, 0, 8'h38, cmd_word(8'hEA, 0));         // R4 lock
        access(1, 0, 8'h3C, 32'hFFFF_FFFF);              // R7
        access(0, 0, 8'h30, 0);                          // R12 idle
        for (int i = 0; i < 400; i++) begin
            logic [7:0]  a;
            logic [31:0] d;
            int unsigned pick;
            pick = $urandom % 8;
            case (pick)
                0, 1: a = 8'h30;
                2, 3: a = 8'h38;
                4, 5, 6: a = 8'h3C;
                default: begin
                    a = 8'($urandom);
                    if (is_mapped(a)) a = 8'h40;
                end
            endcase
            d = $urandom;
            if (a == 8'h38 && ($urandom % 2)) d = cmd_word(($urandom % 2) ? 8'hAE : 8'hEA, d);
            access(1'($urandom), 1'($urandom), a, d);
        end
        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule